// File: doc/BRIEF.md
# Two-Manager AHB-Lite Address-Phase Arbiter

This block lets an instruction-fetch manager and a load/store manager share one AHB-Lite subordinate-side bus. Each cycle it decides which manager owns the address phase and drives that manager's transfer type, direction, size, burst and address onto the shared bus. The losing manager is stalled through its own ready signal. When both managers ask in the same cycle, the loser's address-phase controls are captured into a hold register. They are replayed on the bus once that manager wins, so the manager never has to present them again.

A registered data-phase owner, updated on every cycle that the subordinate accepts, selects the write data sent to the subordinate. It also decides which manager receives the read data. A build-time switch removes the hold registers, and each manager's live inputs then feed the bus mux directly.

Top module: `dual_mgr_ahb_arb`

## Requirements
- R1: A manager requests when its effective transfer type is not 2'b00 (IDLE). The type codes are 2'b10 for NONSEQ and 2'b11 for SEQ. With no manager requesting, the bus shows type 2'b00 and all-zero direction, size, burst and address.
- R2: When both managers request in a cycle that is free to arbitrate, the load/store manager gets the bus.
- R3: If the manager granted in the previous cycle now presents SEQ (2'b11), it keeps the bus whatever the other manager asks.
- R4: If the subordinate ready was low in the previous cycle, the grant repeats the previous cycle's grant. Ownership therefore changes only after a cycle with ready high.
- R5: On a cycle where both managers request and one loses without already holding a stored request, that loser's live direction, size, burst, type and address are captured.
- R6: While a manager has a stored request, the bus shows the stored fields, not its live inputs, whenever it is granted. The stored request is released at the first cycle where that manager is granted with the subordinate ready high.
- R7: Each manager's ready equals the subordinate ready ANDed with NOT(manager requesting AND not granted).
- R8: The data-phase owner takes the current grant on each cycle with subordinate ready high, and holds otherwise. Read data goes to the owner and the other manager sees zero. The bus write data comes from the owner, or is zero when there is no owner.
- R9: A synchronous active-low reset clears stored requests, the grant history, the wait history and the data-phase owner.
- R10: With the save path disabled at build time, nothing is stored and the bus always carries the granted manager's live inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| f_trans | input | 2 | Fetch manager transfer type |
| f_write | input | 1 | Fetch manager direction (1 = write) |
| f_size | input | 3 | Fetch manager transfer size |
| f_burst | input | 3 | Fetch manager burst kind |
| f_addr | input | ADDR_W | Fetch manager address |
| f_wdata | input | DATA_W | Fetch manager write data |
| f_ready | output | 1 | Ready returned to fetch manager |
| f_rdata | output | DATA_W | Read data to fetch manager |
| l_trans | input | 2 | Load/store manager transfer type |
| l_write | input | 1 | Load/store manager direction |
| l_size | input | 3 | Load/store manager transfer size |
| l_burst | input | 3 | Load/store manager burst kind |
| l_addr | input | ADDR_W | Load/store manager address |
| l_wdata | input | DATA_W | Load/store manager write data |
| l_ready | output | 1 | Ready returned to load/store manager |
| l_rdata | output | DATA_W | Read data to load/store manager |
| bus_trans | output | 2 | Shared bus transfer type |
| bus_write | output | 1 | Shared bus direction |
| bus_size | output | 3 | Shared bus transfer size |
| bus_burst | output | 3 | Shared bus burst kind |
| bus_addr | output | ADDR_W | Shared bus address |
| bus_wdata | output | DATA_W | Shared bus write data |
| bus_ready | input | 1 | Subordinate ready |
| bus_rdata | input | DATA_W | Subordinate read data |

## Verification
Checked on every cycle by the bound checker: load/store priority on an open collision, burst lock, grant hold across a wait, the ready stall of a manager with a stored request, capture on a lost collision, retention and release of a stored request, and the data-phase owner update. What only the bench scenarios show is that the stored values, not later live values, reach the bus on replay. They also show that read and write data follow the owner one accepted cycle later, that reset drops a pending request, and that the pass-through build shows live values where the saving build replays. A reference model in the bench follows both builds through directed sequences and pseudo-random traffic.

// File: rtl/arb2_pkg.sv
// Shared encodings and types for the two-manager address-phase arbiter.
package arb2_pkg;
    localparam logic [1:0] TR_IDLE   = 2'b00;
    localparam logic [1:0] TR_NONSEQ = 2'b10;
    localparam logic [1:0] TR_SEQ    = 2'b11;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'b00,
        OWN_DATA  = 2'b01,
        OWN_INSTR = 2'b10
    } owner_e;

    typedef struct packed {
        logic       wr;
        logic [2:0] size;
        logic [2:0] burst;
        logic [1:0] trans;
    } ctl_t;
endpackage

// File: rtl/arb2_hold_stage.sv
// Per-manager capture and replay stage.
// Captures the manager's live address-phase controls when told to save.
// Presents the stored copy while a request is pending, otherwise the live inputs.
// Assumes save and clear are never asserted together.
module arb2_hold_stage
    import arb2_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter bit SAVE_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_t              live_ctl,
    input  logic [ADDR_W-1:0] live_addr,
    input  logic              save,
    input  logic              clear,
    output ctl_t              eff_ctl,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              pend,
    output logic              req,
    output logic              seq
);
    generate
        if (SAVE_EN) begin : g_save
            ctl_t              ctl_q;
            logic [ADDR_W-1:0] addr_q;
            logic              pend_q;

            // Hold register: loads the loser's live fields on a save cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ctl_q  <= '0;
                    addr_q <= '0;
                end else if (save) begin
                    ctl_q  <= live_ctl;
                    addr_q <= live_addr;
                end
            end

            // Pending flag: set on capture, dropped once the replay is accepted.
            always_ff @(posedge clk) begin
                if (!rst_n)     pend_q <= 1'b0;
                else if (save)  pend_q <= 1'b1;
                else if (clear) pend_q <= 1'b0;
            end

            assign eff_ctl  = pend_q ? ctl_q  : live_ctl;
            assign eff_addr = pend_q ? addr_q : live_addr;
            assign pend     = pend_q;
        end else begin : g_pass
            assign eff_ctl  = live_ctl;
            assign eff_addr = live_addr;
            assign pend     = 1'b0;
        end
    endgenerate

    assign req = (eff_ctl.trans != TR_IDLE);
    assign seq = (eff_ctl.trans == TR_SEQ);
endmodule

// File: rtl/arb2_grant_fsm.sv
// Address-phase owner state machine.
// States: no owner, load/store owner, fetch owner (the previous cycle's grant).
// A SEQ beat from the current owner keeps it on the bus.
// After a cycle with subordinate ready low the grant is frozen.
// Otherwise load/store wins over fetch.
module arb2_grant_fsm
    import arb2_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_d,
    input  logic   req_i,
    input  logic   seq_d,
    input  logic   seq_i,
    input  logic   bus_ready,
    output owner_e gnt,
    output logic   hold
);
    owner_e state_q;
    logic   hold_q;

    // Grant decision for the address phase shown this cycle.
    always_comb begin
        if (hold_q)                              gnt = state_q;
        else if (state_q == OWN_DATA  && seq_d)  gnt = OWN_DATA;
        else if (state_q == OWN_INSTR && seq_i)  gnt = OWN_INSTR;
        else if (req_d)                          gnt = OWN_DATA;
        else if (req_i)                          gnt = OWN_INSTR;
        else                                     gnt = OWN_NONE;
    end

    // State update: remember this grant and whether the subordinate stalled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OWN_NONE;
            hold_q  <= 1'b0;
        end else begin
            state_q <= gnt;
            hold_q  <= !bus_ready;
        end
    end

    assign hold = hold_q;
endmodule

// File: rtl/arb2_data_route.sv
// Data-phase routing.
// Registers the owner of each accepted address phase and uses it to steer
// write data to the subordinate and read data back to the right manager.
module arb2_data_route
    import arb2_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  owner_e            gnt,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] f_wdata,
    input  logic [DATA_W-1:0] l_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] f_rdata,
    output logic [DATA_W-1:0] l_rdata,
    output owner_e            dph
);
    owner_e dph_q;

    // Data-phase owner: follows the grant on each accepted cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)         dph_q <= OWN_NONE;
        else if (bus_ready) dph_q <= gnt;
    end

    // Write data select from the data-phase owner.
    always_comb begin
        case (dph_q)
            OWN_DATA:  bus_wdata = l_wdata;
            OWN_INSTR: bus_wdata = f_wdata;
            default:   bus_wdata = '0;
        endcase
    end

    assign f_rdata = (dph_q == OWN_INSTR) ? bus_rdata : '0;
    assign l_rdata = (dph_q == OWN_DATA)  ? bus_rdata : '0;
    assign dph     = dph_q;
endmodule

// File: rtl/dual_mgr_ahb_arb.sv
// Two-manager AHB-Lite arbiter top.
// Merges a fetch manager and a load/store manager onto one subordinate bus.
// Stores the loser of a collision and replays it later.
// Stalls any requesting manager that is not granted.
// Assumes single-cycle address phases and a subordinate that holds ready low
// only to extend the current data phase.
module dual_mgr_ahb_arb
    import arb2_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter bit SAVE_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        f_trans,
    input  logic              f_write,
    input  logic [2:0]        f_size,
    input  logic [2:0]        f_burst,
    input  logic [ADDR_W-1:0] f_addr,
    input  logic [DATA_W-1:0] f_wdata,
    output logic              f_ready,
    output logic [DATA_W-1:0] f_rdata,
    input  logic [1:0]        l_trans,
    input  logic              l_write,
    input  logic [2:0]        l_size,
    input  logic [2:0]        l_burst,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic              l_ready,
    output logic [DATA_W-1:0] l_rdata,
    output logic [1:0]        bus_trans,
    output logic              bus_write,
    output logic [2:0]        bus_size,
    output logic [2:0]        bus_burst,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_rdata
);
    ctl_t              f_live, l_live, f_eff, l_eff, bus_ctl;
    logic [ADDR_W-1:0] f_eaddr, l_eaddr;
    logic              pend_f, pend_l, req_f, req_l, seq_f, seq_l;
    logic              save_f, save_l, clr_f, clr_l, hold;
    owner_e            gnt, dph;

    assign f_live = '{wr: f_write, size: f_size, burst: f_burst, trans: f_trans};
    assign l_live = '{wr: l_write, size: l_size, burst: l_burst, trans: l_trans};

    // Capture the loser of a collision; release a replay once it is accepted.
    assign save_f = req_f && req_l && (gnt == OWN_DATA)  && !pend_f;
    assign save_l = req_f && req_l && (gnt == OWN_INSTR) && !pend_l;
    assign clr_f  = pend_f && (gnt == OWN_INSTR) && bus_ready;
    assign clr_l  = pend_l && (gnt == OWN_DATA)  && bus_ready;

    arb2_hold_stage #(.ADDR_W(ADDR_W), .SAVE_EN(SAVE_EN)) u_hold_f (
        .clk(clk), .rst_n(rst_n), .live_ctl(f_live), .live_addr(f_addr),
        .save(save_f), .clear(clr_f), .eff_ctl(f_eff), .eff_addr(f_eaddr),
        .pend(pend_f), .req(req_f), .seq(seq_f)
    );

    arb2_hold_stage #(.ADDR_W(ADDR_W), .SAVE_EN(SAVE_EN)) u_hold_l (
        .clk(clk), .rst_n(rst_n), .live_ctl(l_live), .live_addr(l_addr),
        .save(save_l), .clear(clr_l), .eff_ctl(l_eff), .eff_addr(l_eaddr),
        .pend(pend_l), .req(req_l), .seq(seq_l)
    );

    arb2_grant_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_d(req_l), .req_i(req_f),
        .seq_d(seq_l), .seq_i(seq_f), .bus_ready(bus_ready),
        .gnt(gnt), .hold(hold)
    );

    arb2_data_route #(.DATA_W(DATA_W)) u_route (
        .clk(clk), .rst_n(rst_n), .gnt(gnt), .bus_ready(bus_ready),
        .f_wdata(f_wdata), .l_wdata(l_wdata), .bus_rdata(bus_rdata),
        .bus_wdata(bus_wdata), .f_rdata(f_rdata), .l_rdata(l_rdata), .dph(dph)
    );

    // Address-phase mux: the granted manager's effective fields, or idle zeros.
    always_comb begin
        case (gnt)
            OWN_DATA:  begin bus_ctl = l_eff; bus_addr = l_eaddr; end
            OWN_INSTR: begin bus_ctl = f_eff; bus_addr = f_eaddr; end
            default:   begin bus_ctl = '0;    bus_addr = '0;      end
        endcase
    end

    assign bus_trans = bus_ctl.trans;
    assign bus_write = bus_ctl.wr;
    assign bus_size  = bus_ctl.size;
    assign bus_burst = bus_ctl.burst;

    // Ready to each manager: stalled while requesting without the grant.
    assign f_ready = bus_ready && !(req_f && gnt != OWN_INSTR);
    assign l_ready = bus_ready && !(req_l && gnt != OWN_DATA);
endmodule

// File: rtl/arb2_checker.sv
// Cycle-by-cycle property checker for dual_mgr_ahb_arb, attached by bind.
module arb2_checker #(
    parameter int ADDR_W  = 32,
    parameter bit SAVE_EN = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        f_trans,
    input logic [1:0]        l_trans,
    input logic [1:0]        bus_trans,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [ADDR_W-1:0] l_addr,
    input logic              bus_ready,
    input logic              f_ready,
    input logic              l_ready,
    input logic [1:0]        gnt,
    input logic [1:0]        dph,
    input logic              hold,
    input logic              pend_f,
    input logic              pend_l
);
    // R1: nothing asked, nothing stored -> idle bus
    p_idle_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (f_trans == 2'b00 && l_trans == 2'b00 && !pend_f && !pend_l) |-> bus_trans == 2'b00);

    // R2: open collision goes to load/store
    p_ls_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !pend_f && !pend_l && l_trans == 2'b10 && f_trans == 2'b10)
        |-> (gnt == 2'b01 && bus_addr == l_addr));

    p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));

    // R3: fetch burst continuation keeps the bus
    p_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !pend_f && f_trans == 2'b11 && $past(gnt) == 2'b10) |-> gnt == 2'b10);

    // R4: grant frozen after a stalled cycle
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> gnt == $past(gnt));

    generate
        if (SAVE_EN) begin : g_saving
            // R5: lost collision is captured
            p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (!pend_f && f_trans != 2'b00 && (l_trans != 2'b00 || pend_l) && gnt == 2'b01)
                |=> pend_f);
            // R6: stored request stays until accepted, then leaves
            p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (pend_f && !(gnt == 2'b10 && bus_ready)) |=> pend_f);
            p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (pend_f && gnt == 2'b10 && bus_ready) |=> !pend_f);
        end else begin : g_passing
            // R10: pass-through build never stores
            p_nostore_r10: assert property (@(posedge clk) disable iff (!rst_n)
                !pend_f && !pend_l);
        end
    endgenerate

    // R7: a manager with a stored request and no grant is stalled
    p_stall_f_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_f && gnt != 2'b10) |-> !f_ready);
    p_stall_l_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_l && gnt != 2'b01) |-> !l_ready);

    // R8: data-phase owner follows an accepted grant
    p_dph_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready && gnt == 2'b01) |=> dph == 2'b01);
endmodule

bind dual_mgr_ahb_arb arb2_checker #(.ADDR_W(ADDR_W), .SAVE_EN(SAVE_EN)) u_arb2_chk (
    .clk(clk), .rst_n(rst_n), .f_trans(f_trans), .l_trans(l_trans),
    .bus_trans(bus_trans), .bus_addr(bus_addr), .l_addr(l_addr),
    .bus_ready(bus_ready), .f_ready(f_ready), .l_ready(l_ready),
    .gnt(gnt), .dph(dph), .hold(hold), .pend_f(pend_f), .pend_l(pend_l)
);

// File: tb/dual_mgr_ahb_arb_test.sv
`timescale 1ns/1ps
module dual_mgr_ahb_arb_test;
    localparam int AW = 16;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [1:0]    f_trans = '0, l_trans = '0;
    logic          f_write = 0, l_write = 0;
    logic [2:0]    f_size = '0, l_size = '0, f_burst = '0, l_burst = '0;
    logic [AW-1:0] f_addr = '0, l_addr = '0;
    logic [DW-1:0] f_wdata = '0, l_wdata = '0, bus_rdata = '0;
    logic          bus_ready = 1'b1;

    logic          a_fr, a_lr, a_bw, b_fr, b_lr, b_bw;
    logic [DW-1:0] a_frd, a_lrd, a_bwd, b_frd, b_lrd, b_bwd;
    logic [1:0]    a_bt, b_bt;
    logic [2:0]    a_bs, a_bb, b_bs, b_bb;
    logic [AW-1:0] a_ba, b_ba;

    dual_mgr_ahb_arb #(.ADDR_W(AW), .DATA_W(DW), .SAVE_EN(1'b1)) uut (
        .clk(clk), .rst_n(rst_n),
        .f_trans(f_trans), .f_write(f_write), .f_size(f_size), .f_burst(f_burst),
        .f_addr(f_addr), .f_wdata(f_wdata), .f_ready(a_fr), .f_rdata(a_frd),
        .l_trans(l_trans), .l_write(l_write), .l_size(l_size), .l_burst(l_burst),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_ready(a_lr), .l_rdata(a_lrd),
        .bus_trans(a_bt), .bus_write(a_bw), .bus_size(a_bs), .bus_burst(a_bb),
        .bus_addr(a_ba), .bus_wdata(a_bwd), .bus_ready(bus_ready), .bus_rdata(bus_rdata)
    );

    dual_mgr_ahb_arb #(.ADDR_W(AW), .DATA_W(DW), .SAVE_EN(1'b0)) uut_p (
        .clk(clk), .rst_n(rst_n),
        .f_trans(f_trans), .f_write(f_write), .f_size(f_size), .f_burst(f_burst),
        .f_addr(f_addr), .f_wdata(f_wdata), .f_ready(b_fr), .f_rdata(b_frd),
        .l_trans(l_trans), .l_write(l_write), .l_size(l_size), .l_burst(l_burst),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_ready(b_lr), .l_rdata(b_lrd),
        .bus_trans(b_bt), .bus_write(b_bw), .bus_size(b_bs), .bus_burst(b_bb),
        .bus_addr(b_ba), .bus_wdata(b_bwd), .bus_ready(bus_ready), .bus_rdata(bus_rdata)
    );

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // Reference model state, index 0 = saving build, 1 = pass-through build
    logic          m_pf [2], m_pl [2], m_hold [2], m_rf [2], m_rl [2];
    logic [8:0]    m_sfc [2], m_slc [2];
    logic [AW-1:0] m_sfa [2], m_sla [2];
    logic [1:0]    m_st [2], m_dph [2], m_gnt [2];

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            m_pf[k] = 0; m_pl[k] = 0; m_hold[k] = 0; m_st[k] = 2'b00; m_dph[k] = 2'b00;
            m_sfc[k] = '0; m_slc[k] = '0; m_sfa[k] = '0; m_sla[k] = '0;
        end
    endtask

    // Settle, compute expected outputs for both builds and compare.
    task automatic apply();
        logic [8:0] fc, lc, efc, elc, ec, ac;
        logic [AW-1:0] efa, ela, ea, aa;
        logic rf, rl, sf, sl, efr, elr;
        logic [1:0] g;
        logic [DW-1:0] efrd, elrd, ewd;
        #1;
        fc = {f_write, f_size, f_burst, f_trans};
        lc = {l_write, l_size, l_burst, l_trans};
        for (int k = 0; k < 2; k++) begin
            efc = m_pf[k] ? m_sfc[k] : fc;  efa = m_pf[k] ? m_sfa[k] : f_addr;
            elc = m_pl[k] ? m_slc[k] : lc;  ela = m_pl[k] ? m_sla[k] : l_addr;
            rf = efc[1:0] != 2'b00; rl = elc[1:0] != 2'b00;
            sf = efc[1:0] == 2'b11; sl = elc[1:0] == 2'b11;
            if (m_hold[k])                  g = m_st[k];
            else if (m_st[k] == 2'b01 && sl) g = 2'b01;
            else if (m_st[k] == 2'b10 && sf) g = 2'b10;
            else if (rl)                    g = 2'b01;
            else if (rf)                    g = 2'b10;
            else                            g = 2'b00;
            ec = (g == 2'b01) ? elc : (g == 2'b10) ? efc : 9'd0;
            ea = (g == 2'b01) ? ela : (g == 2'b10) ? efa : '0;
            efr = bus_ready & ~(rf & (g != 2'b10));
            elr = bus_ready & ~(rl & (g != 2'b01));
            efrd = (m_dph[k] == 2'b10) ? bus_rdata : '0;
            elrd = (m_dph[k] == 2'b01) ? bus_rdata : '0;
            ewd  = (m_dph[k] == 2'b01) ? l_wdata : (m_dph[k] == 2'b10) ? f_wdata : '0;
            m_gnt[k] = g; m_rf[k] = rf; m_rl[k] = rl;
            if (k == 0) begin
                ac = {a_bw, a_bs, a_bb, a_bt}; aa = a_ba;
                check("R6", "bus controls", 32'(ac), 32'(ec));
                check("R6", "bus address", 32'(aa), 32'(ea));
                check("R7", "fetch ready", 32'(a_fr), 32'(efr));
                check("R7", "ls ready", 32'(a_lr), 32'(elr));
                check("R8", "fetch rdata", 32'(a_frd), 32'(efrd));
                check("R8", "ls rdata", 32'(a_lrd), 32'(elrd));
                check("R8", "bus wdata", 32'(a_bwd), 32'(ewd));
            end else begin
                ac = {b_bw, b_bs, b_bb, b_bt}; aa = b_ba;
                check("R10", "bus controls", 32'(ac), 32'(ec));
                check("R10", "bus address", 32'(aa), 32'(ea));
                check("R7", "fetch ready (pass)", 32'(b_fr), 32'(efr));
                check("R7", "ls ready (pass)", 32'(b_lr), 32'(elr));
                check("R8", "fetch rdata (pass)", 32'(b_frd), 32'(efrd));
                check("R8", "ls rdata (pass)", 32'(b_lrd), 32'(elrd));
                check("R8", "bus wdata (pass)", 32'(b_bwd), 32'(ewd));
            end
        end
    endtask

    // Clock edge: advance the model with the inputs held through the edge.
    task automatic tick();
        logic [8:0] fc, lc;
        @(posedge clk);
        fc = {f_write, f_size, f_burst, f_trans};
        lc = {l_write, l_size, l_burst, l_trans};
        if (!m_pf[0] && m_rf[0] && m_rl[0] && m_gnt[0] == 2'b01) begin
            m_pf[0] = 1; m_sfc[0] = fc; m_sfa[0] = f_addr;
        end else if (m_pf[0] && m_gnt[0] == 2'b10 && bus_ready) m_pf[0] = 0;
        if (!m_pl[0] && m_rf[0] && m_rl[0] && m_gnt[0] == 2'b10) begin
            m_pl[0] = 1; m_slc[0] = lc; m_sla[0] = l_addr;
        end else if (m_pl[0] && m_gnt[0] == 2'b01 && bus_ready) m_pl[0] = 0;
        for (int k = 0; k < 2; k++) begin
            m_hold[k] = !bus_ready;
            m_st[k]   = m_gnt[k];
            if (bus_ready) m_dph[k] = m_gnt[k];
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0; f_trans = 0; l_trans = 0; bus_ready = 1;
        repeat (2) @(posedge clk);
        model_reset();
        @(negedge clk);
        rst_n = 1;
    endtask

    function automatic logic [1:0] rnd_trans();
        case ($urandom % 4)
            0: return 2'b00;
            1: return 2'b10;
            2: return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

    task automatic rnd_fetch();
        f_trans = rnd_trans(); f_write = 1'($urandom); f_size = 3'($urandom);
        f_burst = 3'($urandom); f_addr = AW'($urandom); f_wdata = DW'($urandom);
    endtask

    task automatic rnd_ls();
        l_trans = rnd_trans(); l_write = 1'($urandom); l_size = 3'($urandom);
        l_burst = 3'($urandom); l_addr = AW'($urandom); l_wdata = DW'($urandom);
    endtask

    initial begin
        model_reset();
        @(negedge clk);
        do_reset();

        // Reset state
        bus_rdata = 16'hBEEF; apply();
        check("R9", "idle bus after reset", 32'(a_bt), 0);
        check("R9", "fetch ready after reset", 32'(a_fr), 1);
        check("R9", "no data owner after reset", 32'(a_lrd), 0);
        tick();

        // Collision: load/store wins, fetch stored
        f_trans = 2'b10; f_addr = 16'h1000; f_write = 0; f_size = 3'd2; f_burst = 0;
        l_trans = 2'b10; l_addr = 16'h2000; l_write = 1; l_size = 3'd2; l_burst = 0;
        apply();
        check("R2", "collision address", 32'(a_ba), 32'h2000);
        check("R7", "fetch stalled", 32'(a_fr), 0);
        tick();

        // Replay with subordinate wait; fetch live values changed
        l_trans = 2'b00; f_addr = 16'h1111; f_write = 1; f_size = 3'd1; bus_ready = 0;
        apply();
        check("R6", "replayed address", 32'(a_ba), 32'h1000);
        check("R5", "captured size", 32'(a_bs), 32'd2);
        check("R5", "captured direction", 32'(a_bw), 0);
        check("R10", "pass-through live address", 32'(b_ba), 32'h1111);
        tick();

        // Grant frozen after the wait, load/store kept waiting
        bus_ready = 1; l_trans = 2'b10; l_addr = 16'h2222; bus_rdata = 16'h5A5A;
        apply();
        check("R4", "held grant address", 32'(a_ba), 32'h1000);
        check("R4", "ls stalled during hold", 32'(a_lr), 0);
        check("R8", "ls gets read data", 32'(a_lrd), 32'h5A5A);
        check("R8", "fetch sees zero", 32'(a_frd), 0);
        tick();

        f_trans = 2'b00; bus_rdata = 16'h0F0F;
        apply();
        check("R6", "after release", 32'(a_ba), 32'h2222);
        check("R8", "fetch owns data phase", 32'(a_frd), 32'h0F0F);
        tick();

        // Burst in progress while fetch asks
        l_trans = 2'b11; l_addr = 16'h2224; f_trans = 2'b10; f_addr = 16'h3000;
        apply();
        check("R3", "burst keeps ls", 32'(a_ba), 32'h2224);
        check("R7", "fetch stalled by burst", 32'(a_fr), 0);
        tick();
        l_addr = 16'h2228; f_addr = 16'h3333;
        apply();
        check("R3", "burst beat two", 32'(a_ba), 32'h2228);
        tick();
        l_trans = 2'b00;
        apply();
        check("R6", "replay after burst", 32'(a_ba), 32'h3000);
        tick();
        f_trans = 2'b00;
        apply();
        check("R1", "idle type", 32'(a_bt), 0);
        check("R1", "idle address", 32'(a_ba), 0);
        tick();

        // Reset drops a pending request
        f_trans = 2'b10; l_trans = 2'b10; apply(); tick();
        do_reset();
        apply();
        check("R9", "pending cleared by reset", 32'(a_fr), 1);
        check("R9", "bus idle after reset", 32'(a_bt), 0);
        tick();

        // Fetch-only traffic
        l_trans = 0;
        for (int i = 0; i < 400; i++) begin
            rnd_fetch(); bus_ready = ($urandom % 4) != 0; bus_rdata = DW'($urandom);
            apply(); tick();
        end
        // Load/store-only traffic
        f_trans = 0;
        for (int i = 0; i < 400; i++) begin
            rnd_ls(); bus_ready = ($urandom % 4) != 0; bus_rdata = DW'($urandom);
            apply(); tick();
        end
        // Mixed traffic
        for (int i = 0; i < 3000; i++) begin
            rnd_fetch(); rnd_ls(); bus_ready = ($urandom % 4) != 0; bus_rdata = DW'($urandom);
            apply(); tick();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule